// File: doc/BRIEF.md
# Privileged control register access gate

This block guards a single 64-bit control register that only privileged software may reach. Each access presents a strobe, a direction and the privilege level it comes from, along with the nested-virtualization controls, the hypervisor-enabled flag, the presence of the top privilege level with its fine-grained-trap enable, and the debug state. In the same cycle, the block names exactly one of five outcomes: undefined, trap to the hypervisor level, trap to the top level, redirect to memory, or direct register access.

A trap outcome carries its syndrome code. A memory redirect carries the fixed offset at which the register's image lives. A direct read returns the register contents. A direct write is stored on the clock edge that ends the access. Memory traffic and exception entry are handled by neighbouring logic.

Privilege levels are encoded on `acc_lvl` as follows: 0 is user, 1 is OS, 2 is hypervisor and 3 is top.

Top module: `cra_gate`

## Requirements
- R1: An access with `acc_lvl`=0 (user) always gives `res_undef`.
- R2: At level 1 with `hyp_en`, `nest_en` and `nest_mem` all 1, both reads and writes give `res_mem`, and `res_mem_ofs` shows 0x1E8.
- R3: At level 1 with `hyp_en`=1, `nest_en`=1 and `nest_mem`=0, the access gives `res_trap_hyp`, and `res_syndrome` shows 0x18.
- R4: At level 1, every other combination of `hyp_en`, `nest_en` and `nest_mem` gives `res_undef`.
- R5: At level 2 with `top_present`=1, `top_fgt_en`=0, `dbg_halted`=1 and `dbg_sdd`=1, the access gives `res_undef`. This holds for either setting of the HALT_PRIO parameter.
- R6: At level 2 with `top_present`=1 and `top_fgt_en`=0 but not (halted and sdd), the access gives `res_trap_top`, and `res_syndrome` shows 0x18.
- R7: Remaining level-2 accesses and all level-3 accesses give `res_direct`. A direct read drives the register value on `rd_data` in the same cycle.
- R8: With `acc_vld`=1, exactly one outcome output is 1; with `acc_vld`=0, none is. `res_syndrome`, `res_mem_ofs` and `rd_data` are 0 whenever they do not apply.
- R9: A direct write stores `wr_data` at the rising edge where the access is presented. No other outcome changes the register, as later direct reads show.
- R10: After reset the register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_lvl | input | 2 | Privilege level of the access (0 user, 1 OS, 2 hypervisor, 3 top) |
| nest_en | input | 1 | Nested-virtualization enable |
| nest_mem | input | 1 | Nested-virtualization memory-redirect control |
| hyp_en | input | 1 | Hypervisor level enabled |
| top_present | input | 1 | Top privilege level implemented |
| top_fgt_en | input | 1 | Top level allows fine-grained trap controls |
| dbg_halted | input | 1 | Core is in debug halt |
| dbg_sdd | input | 1 | Secure debug disabled |
| wr_data | input | 64 | Write data |
| res_undef | output | 1 | Outcome: undefined |
| res_trap_hyp | output | 1 | Outcome: trap to hypervisor level |
| res_trap_top | output | 1 | Outcome: trap to top level |
| res_mem | output | 1 | Outcome: redirect to memory |
| res_direct | output | 1 | Outcome: direct register access |
| res_syndrome | output | 6 | Trap syndrome code (0x18 on trap, else 0) |
| res_mem_ofs | output | 12 | Memory offset (0x1E8 on redirect, else 0) |
| rd_data | output | 64 | Register value on a direct read, else 0 |

## Verification
All outcome flags, the syndrome, the offset and the read data are combinational. They are due in the same cycle the access is driven. The bench drives each access just after a falling edge and samples a few nanoseconds later, before the next rising edge. A direct write becomes visible one rising edge later. The bench updates its register model only after that edge, so the change is seen on the next direct read and never on the access that caused it.

// File: rtl/cra_pkg.sv
package cra_pkg;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_OS   = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;

  typedef enum logic [2:0] {
    OC_NONE     = 3'd0,
    OC_UNDEF    = 3'd1,
    OC_TRAP_HYP = 3'd2,
    OC_TRAP_TOP = 3'd3,
    OC_MEM      = 3'd4,
    OC_DIRECT   = 3'd5
  } outcome_e;

  localparam int NUM_OC = 5;

  typedef struct packed {
    logic nest_en;
    logic nest_mem;
    logic hyp_en;
    logic top_present;
    logic top_fgt_en;
    logic halted;
    logic sdd;
  } ctl_t;

  // Outcome for an access made at the OS level
  function automatic outcome_e os_outcome(input ctl_t c);
    if (c.hyp_en && c.nest_en && c.nest_mem) return OC_MEM;
    if (c.hyp_en && c.nest_en)               return OC_TRAP_HYP;
    return OC_UNDEF;
  endfunction

  // Outcome for an access made at the hypervisor level
  function automatic outcome_e hyp_outcome(input ctl_t c, input logic halt_prio);
    logic top_blocks;
    top_blocks = c.top_present && !c.top_fgt_en;
    if (c.halted && c.sdd && halt_prio && top_blocks) return OC_UNDEF;
    if (top_blocks) begin
      if (c.halted && c.sdd) return OC_UNDEF;
      return OC_TRAP_TOP;
    end
    return OC_DIRECT;
  endfunction

  // Fixed-priority decision across all levels
  function automatic outcome_e decide(input logic vld, input lvl_e lvl,
                                      input ctl_t c, input logic halt_prio);
    if (!vld) return OC_NONE;
    unique case (lvl)
      LVL_USER: return OC_UNDEF;
      LVL_OS:   return os_outcome(c);
      LVL_HYP:  return hyp_outcome(c, halt_prio);
      default:  return OC_DIRECT;
    endcase
  endfunction

  // One-hot expansion, bit order {direct, mem, trap_top, trap_hyp, undef}
  function automatic logic [NUM_OC-1:0] to_onehot(input outcome_e oc);
    logic [NUM_OC-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_OC; i++) v[i] = (oc == outcome_e'(i + 1));
    return v;
  endfunction

endpackage

// File: rtl/cra_decode.sv
module cra_decode
  import cra_pkg::*;
#(
  parameter logic HALT_PRIO = 1'b0
) (
  input  logic              acc_vld,
  input  logic [1:0]        acc_lvl,
  input  ctl_t              ctl,
  output outcome_e          oc,
  output logic [NUM_OC-1:0] oc_vec
);
  assign oc     = decide(acc_vld, lvl_e'(acc_lvl), ctl, HALT_PRIO);
  assign oc_vec = to_onehot(oc);
endmodule

// File: rtl/cra_store.sv
module cra_store #(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_commit,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] reg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reg_q <= '0;
    else if (wr_commit) reg_q <= wr_data;
  end
endmodule

// File: rtl/cra_resp.sv
module cra_resp #(
  parameter int          REG_W   = 64,
  parameter int          SYN_W   = 6,
  parameter int          OFS_W   = 12,
  parameter logic [SYN_W-1:0] TRAP_SYN = 6'h18,
  parameter logic [OFS_W-1:0] MEM_OFS  = 12'h1E8
) (
  input  logic             is_trap,
  input  logic             is_mem,
  input  logic             is_rd_direct,
  input  logic [REG_W-1:0] reg_q,
  output logic [SYN_W-1:0] syndrome,
  output logic [OFS_W-1:0] mem_ofs,
  output logic [REG_W-1:0] rd_data
);
  assign syndrome = is_trap      ? TRAP_SYN : '0;
  assign mem_ofs  = is_mem       ? MEM_OFS  : '0;
  assign rd_data  = is_rd_direct ? reg_q    : '0;
endmodule

// File: rtl/cra_gate.sv
module cra_gate
  import cra_pkg::*;
#(
  parameter int   REG_W     = 64,
  parameter int   SYN_W     = 6,
  parameter int   OFS_W     = 12,
  parameter logic HALT_PRIO = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [1:0]       acc_lvl,
  input  logic             nest_en,
  input  logic             nest_mem,
  input  logic             hyp_en,
  input  logic             top_present,
  input  logic             top_fgt_en,
  input  logic             dbg_halted,
  input  logic             dbg_sdd,
  input  logic [REG_W-1:0] wr_data,
  output logic             res_undef,
  output logic             res_trap_hyp,
  output logic             res_trap_top,
  output logic             res_mem,
  output logic             res_direct,
  output logic [SYN_W-1:0] res_syndrome,
  output logic [OFS_W-1:0] res_mem_ofs,
  output logic [REG_W-1:0] rd_data
);
  ctl_t              ctl;
  outcome_e          oc;
  logic [NUM_OC-1:0] oc_vec;
  logic              wr_commit;
  logic              rd_direct;
  logic [REG_W-1:0]  reg_q;

  assign ctl = '{nest_en: nest_en, nest_mem: nest_mem, hyp_en: hyp_en,
                 top_present: top_present, top_fgt_en: top_fgt_en,
                 halted: dbg_halted, sdd: dbg_sdd};

  cra_decode #(.HALT_PRIO(HALT_PRIO)) u_dec (
    .acc_vld (acc_vld),
    .acc_lvl (acc_lvl),
    .ctl     (ctl),
    .oc      (oc),
    .oc_vec  (oc_vec)
  );

  assign res_undef    = oc_vec[0];
  assign res_trap_hyp = oc_vec[1];
  assign res_trap_top = oc_vec[2];
  assign res_mem      = oc_vec[3];
  assign res_direct   = oc_vec[4];

  assign wr_commit = (oc == OC_DIRECT) && acc_wr;
  assign rd_direct = (oc == OC_DIRECT) && !acc_wr;

  cra_store #(.REG_W(REG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_commit (wr_commit),
    .wr_data   (wr_data),
    .reg_q     (reg_q)
  );

  cra_resp #(.REG_W(REG_W), .SYN_W(SYN_W), .OFS_W(OFS_W)) u_resp (
    .is_trap      ((oc == OC_TRAP_HYP) || (oc == OC_TRAP_TOP)),
    .is_mem       (oc == OC_MEM),
    .is_rd_direct (rd_direct),
    .reg_q        (reg_q),
    .syndrome     (res_syndrome),
    .mem_ofs      (res_mem_ofs),
    .rd_data      (rd_data)
  );
endmodule

// File: rtl/cra_gate_chk.sv
module cra_gate_chk #(
  parameter int REG_W = 64,
  parameter int SYN_W = 6,
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_vld,
  input logic             acc_wr,
  input logic [1:0]       acc_lvl,
  input logic [REG_W-1:0] wr_data,
  input logic             res_undef,
  input logic             res_trap_hyp,
  input logic             res_trap_top,
  input logic             res_mem,
  input logic             res_direct,
  input logic [SYN_W-1:0] res_syndrome,
  input logic [OFS_W-1:0] res_mem_ofs,
  input logic [REG_W-1:0] reg_q
);
  logic [4:0] flags;
  assign flags = {res_direct, res_mem, res_trap_top, res_trap_hyp, res_undef};

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> $countones(flags) == 1);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> flags == 5'b0);

  // R1
  user_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_lvl == 2'd0) |-> res_undef);

  // R7
  top_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_lvl == 2'd3) |-> res_direct);

  // R3
  trap_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_trap_hyp || res_trap_top) |-> res_syndrome == 6'h18);

  // R2
  mem_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_mem |-> (res_mem_ofs == 12'h1E8 && acc_lvl == 2'd1));

  // R9
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr && res_direct) |=> reg_q == $past(wr_data));

  // R9
  no_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !(acc_wr && res_direct)) |=> $stable(reg_q));
endmodule

bind cra_gate cra_gate_chk #(.REG_W(REG_W), .SYN_W(SYN_W), .OFS_W(OFS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_vld      (acc_vld),
  .acc_wr       (acc_wr),
  .acc_lvl      (acc_lvl),
  .wr_data      (wr_data),
  .res_undef    (res_undef),
  .res_trap_hyp (res_trap_hyp),
  .res_trap_top (res_trap_top),
  .res_mem      (res_mem),
  .res_direct   (res_direct),
  .res_syndrome (res_syndrome),
  .res_mem_ofs  (res_mem_ofs),
  .reg_q        (reg_q)
);

// File: tb/tb_cra_gate.sv
`timescale 1ns/1ps
module tb_cra_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_lvl = 2'd0;
  logic        nest_en = 0, nest_mem = 0, hyp_en = 0, top_present = 0;
  logic        top_fgt_en = 0, dbg_halted = 0, dbg_sdd = 0;
  logic [63:0] wr_data = '0;
  logic        res_undef, res_trap_hyp, res_trap_top, res_mem, res_direct;
  logic [5:0]  res_syndrome;
  logic [11:0] res_mem_ofs;
  logic [63:0] rd_data;

  int checks = 0, fails = 0;
  logic [63:0] model_q = '0;
  bit done = 0;

  always #10 clk = ~clk;

  cra_gate dut (.*);

  // Expected outcome code: 0 none,1 undef,2 trap hyp,3 trap top,4 mem,5 direct
  function automatic int exp_code(bit v, bit [1:0] l, bit ne, bit nm, bit he,
                                  bit tp, bit tf, bit h, bit s);
    if (!v) return 0;
    if (l == 0) return 1;
    if (l == 3) return 5;
    if (l == 1) return (he & ne) ? (nm ? 4 : 2) : 1;
    if (tp & ~tf) return (h & s) ? 1 : 3;
    return 5;
  endfunction

  function automatic string tag_of(int code, bit [1:0] l);
    case (code)
      0: return "R8";
      1: return (l == 0) ? "R1" : (l == 1) ? "R4" : "R5";
      2: return "R3";
      3: return "R6";
      4: return "R2";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [150:0] act, logic [150:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one access after a falling edge, check the combinational results,
  // then let the next rising edge close it.
  task automatic access(bit v, bit w, bit [1:0] l, bit ne, bit nm, bit he,
                        bit tp, bit tf, bit h, bit s, logic [63:0] d, string tag_over);
    int c;
    logic [4:0] ef;
    logic [150:0] act, exp;
    @(negedge clk);
    acc_vld = v; acc_wr = w; acc_lvl = l; nest_en = ne; nest_mem = nm;
    hyp_en = he; top_present = tp; top_fgt_en = tf; dbg_halted = h;
    dbg_sdd = s; wr_data = d;
    #3;
    c  = exp_code(v, l, ne, nm, he, tp, tf, h, s);
    ef = (c == 0) ? 5'b0 : 5'b1 << (c - 1);
    exp = {ef, ((c == 2 || c == 3) ? 6'h18 : 6'h0),
           ((c == 4) ? 12'h1E8 : 12'h0),
           ((c == 5 && !w) ? model_q : 64'h0), 64'h0};
    act = {res_direct, res_mem, res_trap_top, res_trap_hyp, res_undef,
           res_syndrome, res_mem_ofs, rd_data, 64'h0};
    exp[150:146] = {ef[4], ef[3], ef[2], ef[1], ef[0]};
    check((tag_over != "") ? tag_over : tag_of(c, l), act, exp);
    if (c == 5 && w) model_q = d; // R9: visible from the next access on
  endtask

  task automatic read_top(string tag);
    access(1, 0, 3, 0, 0, 0, 0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10: register is zero after reset
    read_top("R10");
    // R8: idle gives no outcome
    access(0, 0, 2, 0, 0, 0, 0, 0, 0, 0, '0, "R8");
    // R1 user read and write
    access(1, 0, 0, 1, 1, 1, 0, 1, 0, 0, '0, "R1");
    access(1, 1, 0, 0, 0, 1, 1, 1, 1, 1, 64'h1, "R1");
    // R7, R9: direct write at top, read at hyp
    access(1, 1, 3, 0, 0, 0, 1, 0, 1, 1, 64'hDEAD_BEEF_0123_4567, "R9");
    access(1, 0, 2, 0, 0, 1, 0, 0, 0, 0, '0, "R7");
    // R2: redirect for read and write, register unchanged
    access(1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 64'hFFFF, "R2");
    access(1, 0, 1, 1, 1, 1, 0, 0, 0, 0, '0, "R2");
    // R3 trap to hypervisor
    access(1, 1, 1, 1, 0, 1, 0, 0, 0, 0, 64'h5, "R3");
    // R4: nest_mem without nest_en, and hypervisor disabled
    access(1, 0, 1, 0, 1, 1, 0, 0, 0, 0, '0, "R4");
    access(1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 64'h7, "R4");
    // R5 halted with sdd, R6 trap to top
    access(1, 1, 2, 0, 0, 1, 1, 0, 1, 1, 64'h9, "R5");
    access(1, 1, 2, 0, 0, 1, 1, 0, 1, 0, 64'hA, "R6");
    access(1, 0, 2, 0, 0, 1, 1, 0, 0, 1, '0, "R6");
    // R9: none of the above writes landed
    read_top("R9");
    // R7: hyp direct when top absent even if halted
    access(1, 1, 2, 0, 0, 0, 0, 0, 1, 1, 64'h0BAD_F00D, "R7");
    read_top("R9");
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [8:0] r;
      r = 9'($urandom);
      access(($urandom % 8) != 0, r[0], 2'($urandom), r[1], r[2], r[3], r[4], r[5],
             r[6], r[7], {$urandom, $urandom}, "");
    end
    read_top("R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule